// File: doc/BRIEF.md
# Flash Command Interrupt and Status Register Bank

This block holds the interrupt, error-status and configuration registers that sit in front of a flash command engine. A host writes a command code into the command register. The code is passed to the engine only while the global interrupt flag is clear. Codes the block does not recognise are refused and reported as errors. The two reset codes are handled locally. When the engine finishes, it reports a one-cycle completion with a kind code and an error flag. The block turns that report into interrupt and error bits.

The host acknowledges an interrupt by writing a mask into the interrupt register; the written value is ANDed in. Dropping the global flag this way also wipes every latched error. An interrupt pin follows the global flag, with a polarity chosen by a configuration bit. A ready pin follows another configuration bit. A cold reset and a warm reset load different interrupt values.

A small state machine gates command acceptance. Its states are:
- HELD: the global flag is set.
- IDLE: the flag is clear and nothing is outstanding.
- BUSY: a command has been forwarded and its completion is still pending.

Its transitions are:
- any to HELD, whenever the next flag value is 1 (completion, refused code, reset);
- HELD to IDLE, when an AND-write clears the flag;
- IDLE to BUSY, on a forwarded command.

Top module: `flash_irq_regs`

## Requirements
- R1: After a cold reset, the registers read as follows: interrupt register (address 4) 0x8080, config1 (address 1) 0x40C0, config2 (address 2) 0x0000, status (address 3) 0x0000, command (address 0) 0x0000. The interrupt pin and the ready pin are both 1, and cmd_valid is 0.
- R2: The block accepts a command write (address 0) in state IDLE if the code is one of 0x0000, 0x0013, 0x0080, 0x001A, 0x001B, 0x0023, 0x0027, 0x002A, 0x002C, 0x0071, 0x0094, 0x0095, 0x00B0, 0x0030 or 0x0065. After the accepting edge, cmd_valid is 1 for exactly one cycle and cmd_code carries the code. The command register then reads that code.
- R3: irq_pin equals interrupt bit 15 XOR the inverse of config1 bit 6. It follows a config1 write at the same edge that stores the write.
- R4: A command write is ignored while interrupt bit 15 is 1. Nothing is forwarded, and the command register keeps its value.
- R5: A write to the interrupt register stores old AND written value. If bit 15 of the result is 0, status bits 13..10 are cleared. If bit 15 stays 1, the status is kept.
- R6: A config1 write drives rdy_pin from written bit 7. A config1 read returns the stored value with bits 4..0 forced to 0.
- R7: A command write in state BUSY (forwarded, completion not yet seen) is ignored.
- R8: A code in state IDLE that is neither forwarded (R2) nor a reset code (R11) is stored in the command register. It is not forwarded. It sets status bit 10 and interrupt bit 15.
- R9: A completion pulse sets interrupt bit 15 plus a kind bit: kind 0 adds none, kind 1 adds bit 5 (erase), kind 2 adds bit 6 (program), kind 3 adds bit 7 (load). With the error flag, the pulse sets status bit 10, plus bit 11, 12 or 13 for kinds 1, 2 and 3.
- R10: When a register write and a completion pulse fall in the same cycle, the write is applied first and the completion bits are ORed in after it.
- R11: A warm reset (warm_rst high, or code 0x00F0 or 0x00F3 accepted in IDLE) loads the interrupt register with 0x8010. It loads all other registers and the ready pin as on a cold reset, except that cmd_code is kept. A warm reset overrides any other event in its cycle.
- R12: Writes to the status register (address 3) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst | input | 1 | Synchronous warm reset request |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data for req_addr (combinational) |
| cmd_valid | output | 1 | One-cycle pulse: command forwarded to the engine |
| cmd_code | output | 16 | Code of the last forwarded command |
| exe_done | input | 1 | Engine completion pulse |
| exe_kind | input | 2 | Completion kind (0 generic, 1 erase, 2 program, 3 load) |
| exe_err | input | 1 | Completion ended in error |
| irq_pin | output | 1 | Interrupt pin |
| rdy_pin | output | 1 | Ready pin |

## Verification
The assertions assume that at most one register access happens per cycle. They also assume that the engine raises exe_done only as a single-cycle pulse with a valid kind. The bench drives every input at the falling edge and holds it for one full cycle. Completion pulses are sometimes sent in states HELD and IDLE, where no command is outstanding, because the registers must absorb them there too. Random runs mix AND-masks, configuration writes, recognised and unrecognised codes, and warm resets.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

    localparam int DW = 16;

    localparam int INT_FLAG  = 15;
    localparam int INT_RST   = 4;
    localparam int INT_ERASE = 5;
    localparam int INT_PROG  = 6;
    localparam int INT_LOAD  = 7;

    localparam int ERR_CMD   = 10;
    localparam int ERR_ERASE = 11;
    localparam int ERR_PROG  = 12;
    localparam int ERR_LOAD  = 13;

    localparam logic [DW-1:0] ERR_MASK = (DW'(1) << ERR_CMD) | (DW'(1) << ERR_ERASE)
                                       | (DW'(1) << ERR_PROG) | (DW'(1) << ERR_LOAD);

    localparam logic [DW-1:0] INT_COLD = (DW'(1) << INT_FLAG) | (DW'(1) << INT_LOAD);
    localparam logic [DW-1:0] INT_WARM = (DW'(1) << INT_FLAG) | (DW'(1) << INT_RST);
    localparam logic [DW-1:0] CFG1_RST = 16'h40C0;
    localparam logic [DW-1:0] CFG2_RST = 16'h0000;

    localparam int CFG_POL_BIT = 6;
    localparam int CFG_RDY_BIT = 7;
    localparam logic [DW-1:0] CFG1_RD_MASK = 16'hFFE0;

    typedef enum logic [1:0] {
        ST_HELD = 2'd0,
        ST_IDLE = 2'd1,
        ST_BUSY = 2'd2
    } gate_state_t;

    typedef enum logic [1:0] {
        CMD_FWD = 2'd0,
        CMD_RST = 2'd1,
        CMD_BAD = 2'd2
    } cmd_class_t;

    function automatic cmd_class_t classify(logic [DW-1:0] code);
        cmd_class_t r;
        case (code)
            16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
            16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
            16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065: r = CMD_FWD;
            16'h00F0, 16'h00F3:                               r = CMD_RST;
            default:                                          r = CMD_BAD;
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] done_int_bits(logic [1:0] kind);
        logic [DW-1:0] r;
        r = DW'(1) << INT_FLAG;
        case (kind)
            2'd1:    r[INT_ERASE] = 1'b1;
            2'd2:    r[INT_PROG]  = 1'b1;
            2'd3:    r[INT_LOAD]  = 1'b1;
            default: r = r;
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] done_err_bits(logic [1:0] kind);
        logic [DW-1:0] r;
        r = DW'(1) << ERR_CMD;
        case (kind)
            2'd1:    r[ERR_ERASE] = 1'b1;
            2'd2:    r[ERR_PROG]  = 1'b1;
            2'd3:    r[ERR_LOAD]  = 1'b1;
            default: r = r;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
    import flash_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          cmd_wr,
    input  logic [DW-1:0] wdata,
    input  logic          flag_next,
    output logic          accept_fwd,
    output logic          accept_bad,
    output logic          warm_any,
    output gate_state_t   state,
    output logic          cmd_valid,
    output logic [DW-1:0] cmd_code,
    output logic [DW-1:0] cmd_reg
);

    gate_state_t state_n;
    cmd_class_t  cls;
    logic        can_take;
    logic        accept_rst;

    always_comb begin
        cls        = classify(wdata);
        can_take   = cmd_wr && (state == ST_IDLE) && !warm_rst;
        accept_fwd = can_take && (cls == CMD_FWD);
        accept_bad = can_take && (cls == CMD_BAD);
        accept_rst = can_take && (cls == CMD_RST);
        warm_any   = warm_rst || accept_rst;
    end

    always_comb begin
        state_n = state;
        if (flag_next) begin
            state_n = ST_HELD;
        end else begin
            unique case (state)
                ST_HELD: state_n = ST_IDLE;
                ST_IDLE: state_n = accept_fwd ? ST_BUSY : ST_IDLE;
                ST_BUSY: state_n = ST_BUSY;
                default: state_n = ST_HELD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HELD;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
            cmd_reg   <= '0;
        end else begin
            cmd_valid <= accept_fwd;
            if (accept_fwd) cmd_code <= wdata;
            if (warm_any)                      cmd_reg <= '0;
            else if (accept_fwd || accept_bad) cmd_reg <= wdata;
        end
    end

endmodule

// File: rtl/flash_irq_bank.sv
module flash_irq_bank
    import flash_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_any,
    input  logic          int_wr,
    input  logic [DW-1:0] wdata,
    input  logic          bad_cmd,
    input  logic          done,
    input  logic [1:0]    kind,
    input  logic          err,
    output logic [DW-1:0] int_q,
    output logic [DW-1:0] stat_q,
    output logic          flag_next
);

    logic [DW-1:0] int_n;
    logic [DW-1:0] stat_n;

    always_comb begin
        int_n  = int_q;
        stat_n = stat_q;
        if (warm_any) begin
            int_n  = INT_WARM;
            stat_n = '0;
        end else begin
            if (int_wr) begin
                int_n = int_q & wdata;
                if (!int_n[INT_FLAG]) stat_n = stat_q & ~ERR_MASK;
            end
            if (bad_cmd) begin
                int_n[INT_FLAG] = 1'b1;
                stat_n[ERR_CMD] = 1'b1;
            end
            if (done) begin
                int_n = int_n | done_int_bits(kind);
                if (err) stat_n = stat_n | done_err_bits(kind);
            end
        end
        flag_next = int_n[INT_FLAG];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= INT_COLD;
            stat_q <= '0;
        end else begin
            int_q  <= int_n;
            stat_q <= stat_n;
        end
    end

endmodule

// File: rtl/flash_cfg_bank.sv
module flash_cfg_bank
    import flash_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_any,
    input  logic          cfg1_wr,
    input  logic          cfg2_wr,
    input  logic [DW-1:0] wdata,
    input  logic          int_flag,
    output logic [DW-1:0] cfg1_q,
    output logic [DW-1:0] cfg2_q,
    output logic          irq_pin,
    output logic          rdy_pin
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg1_q  <= CFG1_RST;
            cfg2_q  <= CFG2_RST;
            rdy_pin <= 1'b1;
        end else if (warm_any) begin
            cfg1_q  <= CFG1_RST;
            cfg2_q  <= CFG2_RST;
            rdy_pin <= 1'b1;
        end else begin
            if (cfg1_wr) begin
                cfg1_q  <= wdata;
                rdy_pin <= wdata[CFG_RDY_BIT];
            end
            if (cfg2_wr) cfg2_q <= wdata;
        end
    end

    always_comb irq_pin = int_flag ^ ~cfg1_q[CFG_POL_BIT];

endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
    import flash_irq_pkg::*;
#(
    parameter int AW     = 4,
    parameter int A_CMD  = 0,
    parameter int A_CFG1 = 1,
    parameter int A_CFG2 = 2,
    parameter int A_STAT = 3,
    parameter int A_INT  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          warm_rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    output logic [15:0]   rsp_rdata,
    output logic          cmd_valid,
    output logic [15:0]   cmd_code,
    input  logic          exe_done,
    input  logic [1:0]    exe_kind,
    input  logic          exe_err,
    output logic          irq_pin,
    output logic          rdy_pin
);

    logic          wr;
    logic          cmd_wr, cfg1_wr, cfg2_wr, int_wr;
    logic          accept_fwd, accept_bad, warm_any, flag_next;
    gate_state_t   gate_state;
    logic [DW-1:0] cmd_reg, int_q, stat_q, cfg1_q, cfg2_q;

    always_comb begin
        wr      = req_valid && req_write;
        cmd_wr  = wr && (req_addr == AW'(A_CMD));
        cfg1_wr = wr && (req_addr == AW'(A_CFG1));
        cfg2_wr = wr && (req_addr == AW'(A_CFG2));
        int_wr  = wr && (req_addr == AW'(A_INT));
    end

    flash_cmd_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .warm_rst   (warm_rst),
        .cmd_wr     (cmd_wr),
        .wdata      (req_wdata),
        .flag_next  (flag_next),
        .accept_fwd (accept_fwd),
        .accept_bad (accept_bad),
        .warm_any   (warm_any),
        .state      (gate_state),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_reg    (cmd_reg)
    );

    flash_irq_bank u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm_any  (warm_any),
        .int_wr    (int_wr),
        .wdata     (req_wdata),
        .bad_cmd   (accept_bad),
        .done      (exe_done),
        .kind      (exe_kind),
        .err       (exe_err),
        .int_q     (int_q),
        .stat_q    (stat_q),
        .flag_next (flag_next)
    );

    flash_cfg_bank u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .warm_any (warm_any),
        .cfg1_wr  (cfg1_wr),
        .cfg2_wr  (cfg2_wr),
        .wdata    (req_wdata),
        .int_flag (int_q[INT_FLAG]),
        .cfg1_q   (cfg1_q),
        .cfg2_q   (cfg2_q),
        .irq_pin  (irq_pin),
        .rdy_pin  (rdy_pin)
    );

    always_comb begin
        if      (req_addr == AW'(A_CMD))  rsp_rdata = cmd_reg;
        else if (req_addr == AW'(A_CFG1)) rsp_rdata = cfg1_q & CFG1_RD_MASK;
        else if (req_addr == AW'(A_CFG2)) rsp_rdata = cfg2_q;
        else if (req_addr == AW'(A_STAT)) rsp_rdata = stat_q;
        else if (req_addr == AW'(A_INT))  rsp_rdata = int_q;
        else                              rsp_rdata = '0;
    end

endmodule

// File: rtl/flash_irq_regs_chk.sv
module flash_irq_regs_chk
    import flash_irq_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_wr,
    input logic          exe_done,
    input logic [DW-1:0] int_q,
    input logic [DW-1:0] stat_q,
    input logic [DW-1:0] cfg1_q,
    input gate_state_t   gate_state,
    input logic          cmd_valid,
    input logic          irq_pin
);

    // R4: a held flag blocks forwarding
    a_r4_flag_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && int_q[INT_FLAG]) |=> !cmd_valid);

    // R7: after a forward the gate is busy, so no second pulse follows
    a_r7_single_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R4: gate state HELD tracks the flag kept in the interrupt bank
    a_r4_state_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == ST_HELD) == int_q[INT_FLAG]);

    // R5: latched errors never outlive a cleared flag
    a_r5_err_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_q[ERR_LOAD:ERR_CMD]) |-> int_q[INT_FLAG]);

    // R9: any operation error carries the command-error bit
    a_r9_op_err_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_q[ERR_LOAD:ERR_ERASE]) |-> stat_q[ERR_CMD]);

    // R9: a completion always raises the flag
    a_r9_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        exe_done |=> int_q[INT_FLAG]);

    // R3: the pin moves only when the flag or the polarity bit moves
    a_r3_pin_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(int_q[INT_FLAG]) && $stable(cfg1_q[CFG_POL_BIT])) |-> $stable(irq_pin));

endmodule

bind flash_irq_regs flash_irq_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .exe_done   (exe_done),
    .int_q      (int_q),
    .stat_q     (stat_q),
    .cfg1_q     (cfg1_q),
    .gate_state (gate_state),
    .cmd_valid  (cmd_valid),
    .irq_pin    (irq_pin)
);

// File: tb/tb_flash_irq_regs.sv
module tb_flash_irq_regs;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          warm_rst = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [15:0]   rsp_rdata;
    logic          cmd_valid;
    logic [15:0]   cmd_code;
    logic          exe_done = 1'b0;
    logic [1:0]    exe_kind = '0;
    logic          exe_err = 1'b0;
    logic          irq_pin;
    logic          rdy_pin;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_irq_regs #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .exe_done(exe_done), .exe_kind(exe_kind), .exe_err(exe_err),
        .irq_pin(irq_pin), .rdy_pin(rdy_pin)
    );

    // behavioural reference model
    logic [15:0] m_int, m_stat, m_cfg1, m_cfg2, m_cmd, m_code;
    bit          m_rdy, m_busy, m_cv;

    function automatic bit fwd_code(logic [15:0] c);
        return c inside {16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
                         16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071,
                         16'h0094, 16'h0095, 16'h00B0, 16'h0030, 16'h0065};
    endfunction

    task automatic m_base(input logic [15:0] iv);
        m_int = iv; m_stat = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0;
        m_cmd = 0; m_rdy = 1; m_busy = 0;
    endtask

    initial begin
        m_base(16'h8080); m_cv = 0; m_code = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_base(16'h8080); m_cv = 0; m_code = 0;
        end else begin
            bit wr;
            bit rcmd;
            wr = req_valid && req_write;
            rcmd = wr && req_addr == 0 && !m_int[15] && !m_busy
                   && (req_wdata == 16'h00F0 || req_wdata == 16'h00F3);
            m_cv = 0;
            if (warm_rst || rcmd) begin
                m_base(16'h8010);
            end else begin
                if (wr) begin
                    case (req_addr)
                        0: if (!m_int[15] && !m_busy) begin
                               m_cmd = req_wdata;
                               if (fwd_code(req_wdata)) begin
                                   m_cv = 1; m_code = req_wdata; m_busy = 1;
                               end else begin
                                   m_stat = m_stat | 16'h0400;
                                   m_int  = m_int | 16'h8000;
                               end
                           end
                        1: begin m_cfg1 = req_wdata; m_rdy = req_wdata[7]; end
                        2: m_cfg2 = req_wdata;
                        4: begin
                               m_int = m_int & req_wdata;
                               if (!m_int[15]) m_stat = m_stat & 16'hC3FF;
                           end
                        default: ;
                    endcase
                end
                if (exe_done) begin
                    m_int = m_int | 16'h8000;
                    if (exe_kind == 1) m_int = m_int | 16'h0020;
                    if (exe_kind == 2) m_int = m_int | 16'h0040;
                    if (exe_kind == 3) m_int = m_int | 16'h0080;
                    if (exe_err) begin
                        m_stat = m_stat | 16'h0400;
                        if (exe_kind == 1) m_stat = m_stat | 16'h0800;
                        if (exe_kind == 2) m_stat = m_stat | 16'h1000;
                        if (exe_kind == 3) m_stat = m_stat | 16'h2000;
                    end
                    m_busy = 0;
                end
            end
        end
    end

    function automatic logic [15:0] m_read(input int a);
        case (a)
            0: return m_cmd;
            1: return m_cfg1 & 16'hFFE0;
            2: return m_cfg2;
            3: return m_stat;
            4: return m_int;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the registered outputs against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit m_irq;
            m_irq = m_int[15] ^ ~m_cfg1[6];
            check(irq_pin == m_irq, "R3 irq_pin", 16'(irq_pin), 16'(m_irq));
            check(rdy_pin == m_rdy, "R6 rdy_pin", 16'(rdy_pin), 16'(m_rdy));
            check(cmd_valid == m_cv, "R2 cmd_valid", 16'(cmd_valid), 16'(m_cv));
            check(cmd_code == m_code, "R2 cmd_code", cmd_code, m_code);
        end
    end

    task automatic cyc(input bit v, input int a, input logic [15:0] d,
                       input bit dn, input logic [1:0] k, input bit e, input bit wm);
        req_valid = v; req_write = v; req_addr = AW'(a); req_wdata = d;
        exe_done = dn; exe_kind = k; exe_err = e; warm_rst = wm;
        @(negedge clk);
        req_valid = 0; req_write = 0; exe_done = 0; exe_err = 0; warm_rst = 0;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        cyc(1, a, d, 0, 0, 0, 0);
    endtask

    task automatic rd(input int a, input logic [15:0] exp, input string tag);
        req_addr = AW'(a);
        #1;
        check(rsp_rdata == exp, tag, rsp_rdata, exp);
    endtask

    task automatic pin(input logic act, input logic exp, input string tag);
        check(act == exp, tag, 16'(act), 16'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 cold reset state
        rd(4, 16'h8080, "R1 int");
        rd(1, 16'h40C0, "R1 cfg1");
        rd(2, 16'h0000, "R1 cfg2");
        rd(3, 16'h0000, "R1 status");
        rd(0, 16'h0000, "R1 cmd");
        pin(irq_pin, 1, "R1 irq"); pin(rdy_pin, 1, "R1 rdy"); pin(cmd_valid, 0, "R1 cmd_valid");
        // R4 command ignored while flag set
        wr(0, 16'h0094);
        pin(cmd_valid, 0, "R4 no forward");
        rd(0, 16'h0000, "R4 cmd kept");
        // R5 AND-clear
        wr(4, 16'h7FFF);
        rd(4, 16'h0080, "R5 and");
        pin(irq_pin, 0, "R3 irq low");
        // R2 forward
        wr(0, 16'h0094);
        pin(cmd_valid, 1, "R2 pulse"); check(cmd_code == 16'h0094, "R2 code", cmd_code, 16'h0094);
        rd(0, 16'h0094, "R2 cmd reg");
        cyc(0, 0, 0, 0, 0, 0, 0);
        pin(cmd_valid, 0, "R2 one cycle");
        // R7 busy ignore
        wr(0, 16'h0080);
        pin(cmd_valid, 0, "R7 busy");
        rd(0, 16'h0094, "R7 cmd kept");
        // R9 erase completion
        cyc(0, 0, 0, 1, 1, 0, 0);
        rd(4, 16'h80A0, "R9 erase done");
        pin(irq_pin, 1, "R9 irq");
        wr(4, 16'h0000);
        wr(0, 16'h0080);
        cyc(0, 0, 0, 1, 2, 1, 0);
        rd(4, 16'h8040, "R9 prog done");
        rd(3, 16'h1400, "R9 prog err");
        // R12 status read-only
        wr(3, 16'hFFFF);
        rd(3, 16'h1400, "R12 status");
        // R5 flag kept keeps status
        wr(4, 16'hFFFF);
        rd(4, 16'h8040, "R5 keep int");
        rd(3, 16'h1400, "R5 keep status");
        wr(4, 16'h7FFF);
        rd(4, 16'h0040, "R5 cleared int");
        rd(3, 16'h0000, "R5 cleared status");
        // R8 unknown code
        wr(0, 16'h0055);
        pin(cmd_valid, 0, "R8 no forward");
        rd(3, 16'h0400, "R8 status");
        rd(4, 16'h8040, "R8 int");
        rd(0, 16'h0055, "R8 cmd reg");
        wr(4, 16'h0000);
        // R6 / R3 config1
        wr(1, 16'h0000);
        pin(rdy_pin, 0, "R6 rdy low");
        pin(irq_pin, 1, "R3 inverted polarity");
        rd(1, 16'h0000, "R6 cfg1");
        wr(1, 16'h00DF);
        rd(1, 16'h00C0, "R6 cfg1 mask");
        pin(rdy_pin, 1, "R6 rdy high");
        pin(irq_pin, 0, "R3 normal polarity");
        // R10 same-cycle write and completion
        wr(0, 16'h0000);
        cyc(1, 4, 16'h0000, 1, 3, 1, 0);
        rd(4, 16'h8080, "R10 int");
        rd(3, 16'h2400, "R10 status");
        wr(4, 16'h0000);
        // R11 reset command
        wr(1, 16'h0000);
        wr(2, 16'h1234);
        wr(0, 16'h00F3);
        rd(4, 16'h8010, "R11 int");
        rd(1, 16'h40C0, "R11 cfg1");
        rd(2, 16'h0000, "R11 cfg2");
        rd(0, 16'h0000, "R11 cmd");
        pin(rdy_pin, 1, "R11 rdy");
        // R11 warm pin
        wr(4, 16'h0000);
        wr(2, 16'h5555);
        cyc(0, 0, 0, 0, 0, 0, 1);
        rd(4, 16'h8010, "R11 warm int");
        rd(2, 16'h0000, "R11 warm cfg2");
        // random mix against the model
        for (int i = 0; i < 4000; i++) begin
            int sel;
            int a;
            logic [15:0] d;
            sel = $urandom_range(0, 9);
            a = $urandom_range(0, 5);
            d = 16'($urandom);
            if (a == 0 && sel < 6) d = (sel < 3) ? 16'h0080 : 16'h0013;
            if (a == 0 && sel == 9) d = 16'h00F0;
            if (a == 4 && sel < 7) d = 16'h7FFF;
            cyc($urandom_range(0, 2) != 0, a, d, $urandom_range(0, 5) == 0,
                2'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 99) == 0);
            for (int r = 0; r < 6; r++) rd(r, m_read(r), "RND read");
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule